// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the control-register port of a mixed-signal audio companion. An external host reaches a bank of fourteen 8-bit configuration registers over a four-wire serial link: an active-low select, a serial clock, a data input and a data output. Every transfer is a 16-bit frame. The frame holds a direction flag, a 7-bit register address and a data byte. On a read, the block sends the byte held at that address back to the host while the host clocks the data phase.

The link pins are sampled by the block's own system clock. Each pin passes through a synchronizer, and serial clock edges are found by comparing the synchronized samples. The registers live in the system clock domain. Their contents go to the rest of the chip as one flat configuration bus. Two short-circuit detector inputs set sticky flags in the output-level register. The host clears those flags by writing that register.

The data output has a separate enable for the pad driver, so the line can be released whenever no transfer is running.

Top module: `spi_regbank`

## Requirements
- R1: After reset the mapped registers hold these values: 0x00:00, 0x01:05, 0x02:05, 0x03:08, 0x04:08, 0x05:00, 0x06:00, 0x07:22, 0x08:09, 0x09:00, 0x0A:00, 0x0C:00, 0x10:00, 0x11:0F.
  - Byte k of `cfg_o` (bits 8k+7..8k) carries the k-th mapped register, counting in ascending address order.
- R2: A frame is read in this order, most significant bit first: a direction bit (1 = read, 0 = write), then 7 address bits, then 8 data bits. The data input is captured on falling edges of the serial clock.
- R3: A write changes the register only when all 16 bits arrive before the select rises. A shorter frame changes nothing. Clock edges after the 16th are ignored.
- R4: On a read, the addressed byte is loaded for output once the 8th bit has been captured. Its MSB is on the data output before the 9th falling edge. The output advances one bit on each rising edge from the 10th onward.
- R5: The output enable is low whenever the select is high. It goes high while the select is low.
- R6: Every rising edge of the select returns the interface to idle, even when the frame was incomplete. The next frame then decodes from its first bit.
- R7: Reads of an unmapped address return 0xFF. Writes to an unmapped address change no register.
- R8: Input `short_l_i` sets bit 3 of register 0x07, and `short_r_i` sets bit 7. Each flag stays set after its input falls. A write to 0x07 loads the written value, which clears the flag, and the write takes precedence in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn_i | input | 1 | Active-low transfer select |
| spi_sclk_i | input | 1 | Serial clock from the host |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| spi_miso_oe_o | output | 1 | Drive enable for the data output pad |
| short_l_i | input | 1 | Left short-circuit detect, sets a sticky flag |
| short_r_i | input | 1 | Right short-circuit detect, sets a sticky flag |
| cfg_o | output | 112 | All mapped registers, byte k is the k-th mapped address |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3, one more than the default. This makes the edge-to-action latency longer, which shows that the protocol timing does not depend on the synchronizer depth. The serial clock is run at one sixteenth of the system clock.

In the stimulus, the host changes the data input to an inverted bit just before each rising edge, and corrects it only later in the high phase. It also samples the data output just before each falling edge. Together these make a design that captures or shifts on the wrong edge fail visibly.

Truncated frames, overlong frames and aborted reads are run alongside normal traffic, as are short-circuit pulses racing register writes.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int ADDR_W      = 7;
  localparam int DATA_W      = 8;
  localparam int NREG        = 14;
  localparam int OLC_IDX     = 7;
  localparam int SHORT_L_BIT = 3;
  localparam int SHORT_R_BIT = 7;

  // address of the k-th mapped register, ascending
  function automatic logic [ADDR_W-1:0] reg_addr(input int idx);
    logic [ADDR_W-1:0] a;
    case (idx)
      10:      a = 7'h0A;
      11:      a = 7'h0C;
      12:      a = 7'h10;
      13:      a = 7'h11;
      default: a = ADDR_W'(idx);
    endcase
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] reg_reset(input int idx);
    logic [DATA_W-1:0] v;
    case (idx)
      1, 2:    v = 8'h05;
      3, 4:    v = 8'h08;
      7:       v = 8'h22;
      8:       v = 8'h09;
      13:      v = 8'h0F;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
  import spi_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_pulse_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_pulse_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int HDR   = 1 + ADDR_W;
  localparam int FRAME = HDR + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic             sclk_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME-1:0] in_sh;
  logic [DATA_W-1:0] out_sh;
  logic             fall_evt, rise_evt;

  assign fall_evt = sclk_q & ~sclk_s;
  assign rise_evt = ~sclk_q & sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      in_sh      <= '0;
      out_sh     <= '0;
      rd_pulse_o <= 1'b0;
      wr_pulse_o <= 1'b0;
      miso_oe_o  <= 1'b0;
    end else if (csn_s) begin
      bit_cnt    <= '0;
      out_sh     <= '0;
      rd_pulse_o <= 1'b0;
      wr_pulse_o <= 1'b0;
      miso_oe_o  <= 1'b0;
    end else begin
      miso_oe_o  <= 1'b1;
      rd_pulse_o <= 1'b0;
      wr_pulse_o <= 1'b0;
      if (fall_evt && bit_cnt < CNT_W'(FRAME)) begin
        in_sh   <= {in_sh[FRAME-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(HDR - 1))   rd_pulse_o <= in_sh[HDR-2];
        if (bit_cnt == CNT_W'(FRAME - 1)) wr_pulse_o <= ~in_sh[FRAME-2];
      end
      if (rd_pulse_o) out_sh <= rd_data_i;
      else if (rise_evt && bit_cnt > CNT_W'(HDR)) out_sh <= {out_sh[DATA_W-2:0], 1'b0};
    end
  end

  assign rd_addr_o = in_sh[ADDR_W-1:0];
  assign wr_addr_o = in_sh[DATA_W +: ADDR_W];
  assign wr_data_o = in_sh[DATA_W-1:0];
  assign miso_o    = out_sh[DATA_W-1];

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso_oe_o);
  assert_cs_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> bit_cnt == '0);
  assert_commit_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> (bit_cnt == CNT_W'(FRAME)) && $past(fall_evt));
  assert_load_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_o |-> bit_cnt == CNT_W'(HDR));
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
  import spi_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_pulse_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               short_l_i,
  input  logic               short_r_i,
  output logic [NREG*DATA_W-1:0] cfg_o
);
  logic [DATA_W-1:0] regs [NREG];
  logic [NREG-1:0]   wr_hit;
  logic              olc_wr, live_q;
  logic [DATA_W-1:0] olc_q;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign wr_hit[k] = wr_pulse_i && (wr_addr_i == reg_addr(k));
    assign cfg_o[k*DATA_W +: DATA_W] = regs[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs[k] <= reg_reset(k);
      else if (wr_hit[k]) regs[k] <= wr_data_i;
      else if (k == OLC_IDX) begin
        if (short_l_i) regs[k][SHORT_L_BIT] <= 1'b1;
        if (short_r_i) regs[k][SHORT_R_BIT] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data_o = '1;
    for (int k = 0; k < NREG; k++)
      if (rd_addr_i == reg_addr(k)) rd_data_o = regs[k];
  end

  assign olc_wr = wr_hit[OLC_IDX];
  assign olc_q  = regs[OLC_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(short_l_i) && !$past(olc_wr) |-> olc_q[SHORT_L_BIT]);
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(olc_q[SHORT_R_BIT]) && !$past(olc_wr) |-> olc_q[SHORT_R_BIT]);
  assert_write_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(olc_wr) |-> olc_q == $past(wr_data_i));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_csn_i,
  input  logic                   spi_sclk_i,
  input  logic                   spi_mosi_i,
  output logic                   spi_miso_o,
  output logic                   spi_miso_oe_o,
  input  logic                   short_l_i,
  input  logic                   short_r_i,
  output logic [NREG*DATA_W-1:0] cfg_o
);
  logic [2:0]        pins_s;
  logic              rd_pulse, wr_pulse;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  spi_rb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({spi_csn_i, spi_sclk_i, spi_mosi_i}),
    .q_o(pins_s)
  );

  spi_rb_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .csn_s(pins_s[2]), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
    .rd_data_i(rd_data),
    .rd_pulse_o(rd_pulse), .rd_addr_o(rd_addr),
    .wr_pulse_o(wr_pulse), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .miso_o(spi_miso_o), .miso_oe_o(spi_miso_oe_o)
  );

  spi_rb_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pulse_i(wr_pulse), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .short_l_i(short_l_i), .short_r_i(short_r_i),
    .cfg_o(cfg_o)
  );
endmodule

// File: tb/spi_regbank_tb_top.sv
module spi_regbank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic sh_l = 1'b0, sh_r = 1'b0;
  logic [111:0] cfg;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct { string req; logic [7:0] val; } exp_t;
  exp_t exp_q[$];
  exp_t cur;
  logic [7:0] act_byte;
  logic [7:0] dummy;
  event rd_done;

  // bench-side map: addresses and expected contents
  logic [6:0] map_addr [14] = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06,
                                7'h07, 7'h08, 7'h09, 7'h0A, 7'h0C, 7'h10, 7'h11};
  logic [7:0] model [14]    = '{8'h00, 8'h05, 8'h05, 8'h08, 8'h08, 8'h00, 8'h00,
                                8'h22, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F};

  always #10 clk = ~clk;

  spi_regbank #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_csn_i(csn), .spi_sclk_i(sclk), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .short_l_i(sh_l), .short_r_i(sh_r),
    .cfg_o(cfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // host side: input bit inverted at the rise, corrected mid-high; output sampled before fall
  task automatic spi_frame(input logic [15:0] word, input int nbits, output logic [7:0] rd);
    logic bitv;
    rd = 8'h00;
    csn = 1'b0;
    wclk(8);
    for (int b = 0; b < nbits; b++) begin
      bitv = (b < 16) ? word[15-b] : 1'b0;
      mosi = ~bitv;
      sclk = 1'b1;
      wclk(4);
      mosi = bitv;
      wclk(4);
      if (b >= 8 && b < 16) rd = {rd[6:0], miso};
      sclk = 1'b0;
      wclk(8);
    end
    wclk(10);
    csn = 1'b1;
    wclk(10);
  endtask

  task automatic spi_read(input logic [6:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r;
    exp_q.push_back('{req, exp});
    spi_frame({1'b1, a, 8'h00}, 16, r);
    act_byte = r;
    ->rd_done;
    wclk(1);
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] d);
    spi_frame({1'b0, a, d}, 16, dummy);
  endtask

  task automatic check_bus(input string req);
    for (int k = 0; k < 14; k++) check(req, 32'(cfg[k*8 +: 8]), 32'(model[k]));
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_done);
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        cur = exp_q.pop_front();
        check(cur.req, 32'(act_byte), 32'(cur.val));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    wclk(5);
    check("R5 reset oe", 32'(miso_oe), 32'd0);
    check_bus("R1 reset bus");
    rst_n = 1'b1;
    wclk(5);
    check_bus("R1 bus after release");

    for (int k = 0; k < 14; k++) spi_read(map_addr[k], model[k], "R1/R2/R4 reset readback");

    // normal writes, varied patterns
    spi_write(7'h03, 8'hA5); model[3] = 8'hA5;
    check("R3 write 0x03 on bus", 32'(cfg[3*8 +: 8]), 32'hA5);
    spi_read(7'h03, 8'hA5, "R2/R4 readback 0x03");
    spi_write(7'h11, 8'h3C); model[13] = 8'h3C;
    spi_read(7'h11, 8'h3C, "R2 readback 0x11");
    spi_write(7'h00, 8'h81); model[0] = 8'h81;
    spi_read(7'h00, 8'h81, "R4 readback 0x00 edge bits");

    // unmapped
    spi_read(7'h0B, 8'hFF, "R7 unmapped 0x0B");
    spi_read(7'h7F, 8'hFF, "R7 unmapped 0x7F");
    spi_write(7'h0B, 8'h12);
    spi_write(7'h12, 8'h34);
    check_bus("R7 unmapped write no effect");

    // truncated writes
    spi_frame({1'b0, 7'h05, 8'h77}, 12, dummy);
    check("R3 12-bit frame no commit", 32'(cfg[5*8 +: 8]), 32'h00);
    spi_frame({1'b0, 7'h05, 8'h77}, 15, dummy);
    check("R3 15-bit frame no commit", 32'(cfg[5*8 +: 8]), 32'h00);
    spi_read(7'h05, 8'h00, "R6 fresh decode after abort");

    // overlong frame
    spi_frame({1'b0, 7'h06, 8'h5A}, 20, dummy); model[6] = 8'h5A;
    check("R3 overlong frame commits once", 32'(cfg[6*8 +: 8]), 32'h5A);
    check_bus("R3 overlong frame other regs");

    // output enable framing
    csn = 1'b0;
    wclk(8);
    check("R5 oe while selected", 32'(miso_oe), 32'd1);
    csn = 1'b1;
    wclk(8);
    check("R5 oe released", 32'(miso_oe), 32'd0);

    // aborted read then a fresh write
    spi_frame({1'b1, 7'h08, 8'h00}, 10, dummy);
    spi_write(7'h01, 8'h1E); model[1] = 8'h1E;
    spi_read(7'h01, 8'h1E, "R6 write after aborted read");
    spi_read(7'h08, 8'h09, "R6 unrelated reg intact");

    // sticky short flags
    sh_l = 1'b1; wclk(2); sh_l = 1'b0; wclk(2);
    spi_read(7'h07, 8'h2A, "R8 left flag set");
    wclk(20);
    spi_read(7'h07, 8'h2A, "R8 left flag held");
    sh_r = 1'b1; wclk(1); sh_r = 1'b0; wclk(2);
    check("R8 right flag on bus", 32'(cfg[7*8 +: 8]), 32'hAA);
    spi_write(7'h07, 8'h22);
    spi_read(7'h07, 8'h22, "R8 write clears flags");
    spi_write(7'h07, 8'h80); model[7] = 8'h80;
    check("R8 written flag value", 32'(cfg[7*8 +: 8]), 32'h80);
    check_bus("R1 final bus");

    wclk(10);
    report();
  end
endmodule